// File: doc/BRIEF.md
# System/User Counter-Timer

This peripheral keeps a step counter that moves forward once every 500 ns, a programmable limit and a reached flag, and it drives a single interrupt line. The timebase comes from a prescaler that divides the system clock by a parameter. Software reaches the block through a 32-bit word register port. Accesses take one cycle and add no wait states. Each step adds one at bit 9 of the visible count, so the nine low bits of the count are always zero.

In system mode the block is a periodic limit timer. When the count reaches the limit it folds back to zero, sets the reached flag and raises the interrupt. Software acknowledges the event by reading the limit register. In user mode the interrupt is held low. The block then becomes a free-running counter, 54 steps wide, that software can start and stop and read as two words. A strap taken at reset can lock the block in system mode.

Top module: `systimer`

## Requirements
- R1: The register index is address bits [4:2]: 0 limit-and-restart, 1 count, 2 limit-only, 3 run control, 4 mode. A read of index 5, 6 or 7 returns zero.
- R2: A limit write keeps data bits 30:9 only. When that field is zero the limit becomes 0x7FFFFE00. A system-mode read of index 0 returns the limit with bits 31 and 8:0 zero.
- R3: A write to index 0 sets the count to zero and drops the interrupt. A write to index 2 changes the limit and leaves the running count untouched.
- R4: While running, the count rises by 0x200 once every TICK_DIV clock cycles, counted from a restart. Count bits 8:0 always read zero.
- R5: In system mode, when the next step would bring the count to or past the limit, the count returns to zero, the reached flag is set and the interrupt is asserted. This repeats every limit/0x200 steps.
- R6: In system mode, a read of index 0 clears the interrupt and the reached flag. When a wrap falls in the same cycle as this read, the wrap wins and both stay set.
- R7: A read of index 1 returns {reached, count[30:0]} in system mode and count[31:0] in user mode.
- R8: In user mode, a read of index 0 returns count bits 62:32 with bit 31 zero, and it has no acknowledge side effect.
- R9: In user mode, a write to index 3 stops the counter when data bit 0 is 1 and starts it when bit 0 is 0. The count holds while stopped. In system mode these writes are ignored and the counter runs whatever the stopped state. Bit 0 of index 3 reads back the stopped state.
- R10: Data bit 0 of an index-4 write selects user (1) or system (0) mode, and bit 0 of index 4 reads the mode back. The mode does not change while the block is locked (configured mode 2). Entering user mode drops the interrupt and sets the limit to all ones. Every index-4 write sets the count to zero.
- R11: After reset the limit is 0x7FFFFE00, the count is 0, reached is 0, stopped is 1, the interrupt is low, and the mode is cfg_mode with bit 0 cleared.
- R12: The interrupt is never high while user mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Mode strap sampled at reset; only bit 1 is kept (2 locks system mode) |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address; bits [4:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Timer interrupt, level |

## Verification
The assertions assume that the bus strobe lasts one cycle per access. They also assume that cfg_mode is held stable around reset and that no access is made while reset is asserted, so the mode register only ever holds 0, 1 or 2. The bench issues each access through a task that raises the strobe for exactly one clock edge. It changes cfg_mode only while reset is low. Every check is timed from a restart write, so the prescaler phase is always known.

// File: rtl/systimer_pkg.sv
package systimer_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 5;

   typedef enum logic [2:0] {
      IDX_LIM_RST  = 3'd0,
      IDX_COUNT    = 3'd1,
      IDX_LIM_KEEP = 3'd2,
      IDX_RUN      = 3'd3,
      IDX_MODE     = 3'd4
   } reg_idx_e;

   typedef enum logic [1:0] {
      MODE_SYS    = 2'd0,
      MODE_USER   = 2'd1,
      MODE_LOCKED = 2'd2,
      MODE_RSVD   = 2'd3
   } tmode_e;
endpackage

// File: rtl/systimer_prescale.sv
module systimer_prescale #(
   parameter int unsigned DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_pass
         logic unused_pass;
         assign unused_pass = clk ^ rst_n;
         assign tick = ~clr;
      end else begin : g_div
         localparam int unsigned CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         logic          at_end;

         assign at_end = (cnt_q == CW'(DIV - 1));
         assign tick   = at_end & ~clr;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr || at_end)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/systimer_limit_mask.sv
module systimer_limit_mask #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SUB_BITS = 9,
   parameter int unsigned LIM_W    = 22
) (
   input  logic [DATA_W-1:0] wdata,
   output logic [LIM_W-1:0]  limit
);
   logic [LIM_W-1:0] field;
   logic             unused_bits;

   assign field       = wdata[SUB_BITS+LIM_W-1:SUB_BITS];
   assign unused_bits = ^{wdata[DATA_W-1:SUB_BITS+LIM_W], wdata[SUB_BITS-1:0]};
   assign limit       = (field == '0) ? '1 : field;
endmodule

// File: rtl/systimer_counter.sv
module systimer_counter #(
   parameter int unsigned STEP_W = 54,
   parameter int unsigned LIM_W  = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   input  logic              wrap_en,
   input  logic [LIM_W-1:0]  limit,
   output logic [STEP_W-1:0] steps,
   output logic              wrap
);
   logic [STEP_W-1:0] steps_q;
   logic [STEP_W-1:0] next_steps;
   logic              hit;

   assign next_steps = steps_q + 1'b1;
   assign hit        = wrap_en && (next_steps >= STEP_W'(limit));
   assign wrap       = advance && !restart && hit;
   assign steps      = steps_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         steps_q <= '0;
      else if (restart)
         steps_q <= '0;
      else if (advance)
         steps_q <= hit ? '0 : next_steps;
   end
endmodule

// File: rtl/systimer.sv
module systimer
   import systimer_pkg::*;
#(
   parameter int unsigned TICK_DIV = 125,
   parameter int unsigned STEP_W   = 54,
   parameter int unsigned SUB_BITS = 9,
   parameter int unsigned LIM_W    = 22
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_mode,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq
);
   localparam int unsigned CNT_W = STEP_W + SUB_BITS;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("systimer: TICK_DIV must be at least 1");
      end
      if (CNT_W > 63) begin : g_bad_cnt
         $error("systimer: STEP_W + SUB_BITS must not exceed 63");
      end
      if (SUB_BITS + LIM_W > DATA_W - 1) begin : g_bad_lim
         $error("systimer: limit field collides with the flag bit");
      end
      if (STEP_W < LIM_W) begin : g_bad_step
         $error("systimer: STEP_W must be at least LIM_W");
      end
   endgenerate

   reg_idx_e          idx;
   logic              wr, rd, user;
   logic              wr_lim_rst, wr_lim_keep, wr_run, wr_mode;
   logic              mode_free, enter_user, rd_ack, restart, run;
   logic              tick, wrap;
   logic [LIM_W-1:0]  new_limit;
   logic [STEP_W-1:0] steps;
   logic              unused_in;

   tmode_e            mode_q;
   logic [LIM_W-1:0]  limit_q;
   logic              stopped_q;
   logic              reached_q;
   logic              irq_q;

   assign idx       = reg_idx_e'(bus_addr[4:2]);
   assign unused_in = ^{bus_addr[1:0], cfg_mode[0]};
   assign wr        = bus_sel && bus_we;
   assign rd        = bus_sel && !bus_we;
   assign user      = (mode_q == MODE_USER);

   assign wr_lim_rst  = wr && (idx == IDX_LIM_RST);
   assign wr_lim_keep = wr && (idx == IDX_LIM_KEEP);
   assign wr_run      = wr && (idx == IDX_RUN);
   assign wr_mode     = wr && (idx == IDX_MODE);
   assign mode_free   = (mode_q == MODE_SYS) || (mode_q == MODE_USER);
   assign enter_user  = wr_mode && mode_free && bus_wdata[0];
   assign rd_ack      = rd && (idx == IDX_LIM_RST) && !user;
   assign restart     = wr_lim_rst || wr_mode;
   assign run         = !user || !stopped_q;

   systimer_limit_mask #(
      .DATA_W   (DATA_W),
      .SUB_BITS (SUB_BITS),
      .LIM_W    (LIM_W)
   ) u_mask (
      .wdata (bus_wdata),
      .limit (new_limit)
   );

   systimer_prescale #(
      .DIV (TICK_DIV)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart || !run),
      .tick  (tick)
   );

   systimer_counter #(
      .STEP_W (STEP_W),
      .LIM_W  (LIM_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .advance (tick && run),
      .wrap_en (!user),
      .limit   (limit_q),
      .steps   (steps),
      .wrap    (wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= tmode_e'({cfg_mode[1], 1'b0});
         limit_q   <= '1;
         stopped_q <= 1'b1;
         reached_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         if (wr_mode && mode_free)
            mode_q <= bus_wdata[0] ? MODE_USER : MODE_SYS;

         if (enter_user)
            limit_q <= '1;
         else if (wr_lim_rst || wr_lim_keep)
            limit_q <= new_limit;

         if (wr_run && user)
            stopped_q <= bus_wdata[0];

         if (wrap)
            reached_q <= 1'b1;
         else if (rd_ack)
            reached_q <= 1'b0;

         if (wrap && !user)
            irq_q <= 1'b1;
         else if (wr_lim_rst || rd_ack || enter_user)
            irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

   logic [CNT_W-1:0]  count_full;
   logic [63:0]       cnt_ext;
   logic [DATA_W-1:0] hi_word, lo_word, lim_word;

   assign count_full = {steps, {SUB_BITS{1'b0}}};
   assign cnt_ext    = 64'(count_full);
   assign hi_word    = cnt_ext[63:32] & 32'h7FFF_FFFF;
   assign lo_word    = cnt_ext[31:0];
   assign lim_word   = DATA_W'({limit_q, {SUB_BITS{1'b0}}});

   always_comb begin
      case (idx)
         IDX_LIM_RST: bus_rdata = user ? hi_word : lim_word;
         IDX_COUNT:   bus_rdata = user ? lo_word : {reached_q, lo_word[30:0]};
         IDX_RUN:     bus_rdata = {{(DATA_W-1){1'b0}}, stopped_q};
         IDX_MODE:    bus_rdata = {{(DATA_W-1){1'b0}}, mode_q[0]};
         default:     bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/systimer_chk.sv
module systimer_chk #(
   parameter int unsigned STEP_W = 54
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [4:0]        bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              irq,
   input logic [1:0]        mode_q,
   input logic              stopped_q,
   input logic              reached_q,
   input logic              wrap,
   input logic [STEP_W-1:0] steps
);
   logic rd_cnt, wr_rst, wr_mode;
   assign rd_cnt  = bus_sel && !bus_we && (bus_addr[4:2] == 3'd1);
   assign wr_rst  = bus_sel && bus_we && (bus_addr[4:2] == 3'd0);
   assign wr_mode = bus_sel && bus_we && (bus_addr[4:2] == 3'd4);

   a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt |-> (bus_rdata[8:0] == 9'd0));

   a_r12_no_irq_user: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd1) |-> !irq);

   a_r3_restart_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst |=> (!irq && steps == '0));

   a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (reached_q && steps == '0));

   a_r9_sys_ignores_run: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != 2'd1) |=> $stable(stopped_q));

   a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd1 && stopped_q && !wr_rst && !wr_mode) |=> $stable(steps));

   a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd2) |=> (mode_q == 2'd2));
endmodule

bind systimer systimer_chk #(.STEP_W(STEP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .mode_q    (mode_q),
   .stopped_q (stopped_q),
   .reached_q (reached_q),
   .wrap      (wrap),
   .steps     (steps)
);

// File: tb/sim_systimer.sv
`timescale 1ns/1ps
module sim_systimer;
   localparam int unsigned DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'd1;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   systimer #(.TICK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // monitor: compares read data just before the edge that completes the read
   always @(negedge clk) begin
      if (rst_n && bus_sel && !bus_we) begin
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
               errors++;
               $display("FAIL %s actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'(idx << 2); bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input int idx, input logic [31:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'(idx << 2);
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s actual %b expected %b", t, irq, e);
      end
   endtask

   task automatic do_reset(input logic [1:0] m);
      rst_n = 1'b0; cfg_mode = m;
      idle(4);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads not seen, actual %0d expected 0", exp_q.size(), exp_q.size());
         end
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      // R11 reset state; cfg bit 0 dropped
      do_reset(2'd1);
      chk_irq(1'b0, "R11 irq after reset");
      rd(1, 32'h0, "R11 count after reset");
      rd(3, 32'h1, "R11 stopped after reset");
      rd(4, 32'h0, "R11 mode bit0 dropped");
      rd(0, 32'h7FFF_FE00, "R11 limit after reset");

      // R4 R3 R7 counting and restart
      wr(0, 32'h0010_0000);
      idle(9);
      rd(1, 32'h0000_0400, "R4 two steps");
      idle(5);
      rd(1, 32'h0000_0600, "R4 three steps");
      wr(2, 32'h0020_0000);
      rd(1, 32'h0000_0800, "R3 index2 keeps count");
      wr(0, 32'h0020_0000);
      rd(1, 32'h0, "R3 index0 restarts count");
      rd(5, 32'h0, "R1 index5 reads zero");
      rd(7, 32'h0, "R1 index7 reads zero");

      // R5 R6 periodic wrap and acknowledge
      wr(0, 32'h0000_0600);
      idle(11);
      rd(1, 32'h0000_0400, "R5 before wrap");
      chk_irq(1'b1, "R5 irq at wrap");
      rd(1, 32'h8000_0000, "R7 reached flag in bit31");
      rd(0, 32'h0000_0600, "R2 limit readback");
      chk_irq(1'b0, "R6 ack clears irq");
      rd(1, 32'h0, "R6 ack clears reached");
      idle(8);
      chk_irq(1'b0, "R5 no early second wrap");
      idle(1);
      chk_irq(1'b1, "R5 periodic second wrap");
      rd(0, 32'h0000_0600, "R6 ack");
      idle(10);
      rd(0, 32'h0000_0600, "R6 ack same cycle as wrap");
      chk_irq(1'b1, "R6 wrap wins over ack");
      rd(1, 32'h8000_0000, "R6 reached kept");
      rd(0, 32'h0000_0600, "R6 ack again");
      chk_irq(1'b0, "R6 cleared");

      // R2 limit masking
      wr(2, 32'h0000_01FF);
      rd(0, 32'h7FFF_FE00, "R2 zero field becomes max");
      wr(2, 32'h8000_0A00);
      rd(0, 32'h0000_0A00, "R2 bit31 dropped");
      wr(2, 32'hFFFF_FFFF);
      rd(0, 32'h7FFF_FE00, "R2 all ones masked");

      // R9 run control ignored in system mode
      wr(3, 32'h0);
      rd(3, 32'h1, "R9 system ignores start");

      // R10 R12 R8 R7 R9 user mode
      wr(0, 32'h0000_0400);
      idle(10);
      chk_irq(1'b1, "R5 short limit wrap");
      wr(4, 32'h1);
      chk_irq(1'b0, "R10 enter user drops irq");
      rd(4, 32'h1, "R10 user mode readback");
      rd(0, 32'h0, "R8 high word zero");
      rd(3, 32'h1, "R9 still stopped");
      idle(20);
      rd(1, 32'h0, "R9 stopped count holds");
      wr(3, 32'h0);
      idle(9);
      rd(1, 32'h0000_0400, "R7 user low word no flag");
      wr(3, 32'h1);
      idle(20);
      rd(1, 32'h0000_0400, "R9 stop holds count");
      rd(3, 32'h1, "R9 stopped readback");
      chk_irq(1'b0, "R12 irq low in user mode");
      wr(4, 32'h0);
      rd(1, 32'h8000_0000, "R8 user read did not ack");
      rd(0, 32'h7FFF_FE00, "R10 limit set to ones");
      rd(4, 32'h0, "R10 system mode readback");

      // R10 locked mode
      do_reset(2'd2);
      rd(4, 32'h0, "R11 locked mode bit0");
      wr(0, 32'h0010_0000);
      idle(9);
      rd(1, 32'h0000_0400, "R4 locked counts");
      wr(4, 32'h1);
      rd(1, 32'h0, "R10 mode write restarts");
      rd(4, 32'h0, "R10 locked mode unchanged");
      rd(3, 32'h1, "R11 stopped after second reset");

      idle(2);
      finish_run();
   end
endmodule